// File: doc/BRIEF.md
# Interrupt distributor register bank

This block holds the per-line state of a small interrupt controller. Software reaches it through a simple 32-bit register port with a one-cycle write strobe and a combinational read. Peripherals drive raw interrupt inputs into it. For every line it keeps an enable bit, a pending bit, an active bit, an 8-bit priority, a group bit and a trigger mode. A CPU interface block sits downstream. It sees the lines that are enabled and pending, together with their priorities. It returns acknowledge and deactivate strobes, which move lines through the pending, active and inactive states.

Enable, pending and active state cannot be written as plain words. Each one has two register windows: one where a 1 sets bits and one where a 1 clears them. This lets several agents change individual lines without a read-modify-write race. The low `NUM_SW` lines are software-generated and are raised through a dedicated register. Each higher line can be latched on a rising edge or followed as a level.

The CPU interface reads `fwd_pend` and `fwd_prio` every cycle and picks its own winner. `fwd_pend` is gated by a global enable.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset the following hold. The control word reads 0. Enable reads 1 for software lines 0..15 and 0 for all other lines. Pending, active, group and all priorities read 0. Trigger fields read 0b10 for software lines and 0b01 for peripheral lines.
- R2: `fwd_pend[i]` is 1 only when bit 0 of the control word (offset 0x000) is 1 and line i is both enabled and pending. Clearing that bit hides every line without changing the stored pending state.
- R3: The read-only word at offset 0x004 returns the number of implemented lines (64 by default).
- R4: Each state has a set window and a clear window, with 32 lines per word and line 32w+b at bit b of word w. Enable uses 0x100/0x180, pending uses 0x200/0x280 and active uses 0x300/0x380. Writing 1 to a bit sets or clears that line, and writing 0 leaves it unchanged. Reading either window returns the current bitmap.
- R5: Priorities are 8 bits per line, four lines per word from offset 0x400. Line 4k+j occupies bits [8j+7:8j] of word k. Every write is read back unchanged.
- R6: Trigger fields are 2 bits per line, sixteen lines per word from offset 0xC00. Line 16m+j occupies bits [2j+1:2j] of word m. Software lines always read 0b10 and ignore writes. For a peripheral line, bit 2j+1 of a write selects edge mode (read back as 0b10) when 1, and level mode (read back as 0b01) when 0.
- R7: An edge-mode line becomes pending on the cycle after its input rises. It stays pending after the input falls, until it is cleared or acknowledged.
- R8: A level-mode line reads as pending whenever its input is high and the line is not active. It stops reading as pending when the input goes low.
- R9: Writing to offset 0xF00 sets the pending bit of software line `wdata[3:0]`. All other bits of the written word are ignored.
- R10: The group bitmap at 0x080/0x084 reads back what was written and has no effect on forwarding.
- R11: An acknowledge strobe clears the named line's pending latch and sets its active bit. A deactivate strobe clears the active bit. Both strobes override a register write to the same line in the same cycle.
- R12: `fwd_prio[8i+7:8i]` always carries line i's stored priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W (12) | Byte offset of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_in | input | NUM_LINES-NUM_SW (48) | Peripheral inputs; bit k feeds line NUM_SW+k |
| ack_valid | input | 1 | Acknowledge strobe from the CPU interface |
| ack_id | input | clog2(NUM_LINES) (6) | Line being acknowledged |
| deact_valid | input | 1 | Deactivate strobe from the CPU interface |
| deact_id | input | clog2(NUM_LINES) (6) | Line being deactivated |
| fwd_pend | output | NUM_LINES (64) | Lines that are enabled and pending, gated by the global enable |
| fwd_prio | output | NUM_LINES*8 (512) | Priority of every line, packed |

## Verification
The assertions check the following on every cycle:
- a strobe-driven clear always wins inside each state bank;
- a strobe-driven set always lands;
- a bank with no write and no strobe holds its value;
- an acknowledge always leaves the named line active;
- a software-interrupt write always leaves the named line pending.

Only the bench scenarios show the following:
- the address decode of each window and its read-back;
- the fixed trigger codes of the software lines;
- level following versus edge latching on a real input waveform;
- the global enable hiding a line that is still pending;
- a group write leaving forwarding unchanged.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
   // register word offsets (byte addresses)
   localparam int unsigned OFS_CTRL   = 'h000;
   localparam int unsigned OFS_TYPE   = 'h004;
   localparam int unsigned OFS_GROUP  = 'h080;
   localparam int unsigned OFS_EN_SET = 'h100;
   localparam int unsigned OFS_EN_CLR = 'h180;
   localparam int unsigned OFS_PD_SET = 'h200;
   localparam int unsigned OFS_PD_CLR = 'h280;
   localparam int unsigned OFS_AC_SET = 'h300;
   localparam int unsigned OFS_AC_CLR = 'h380;
   localparam int unsigned OFS_PRIO   = 'h400;
   localparam int unsigned OFS_TRIG   = 'hC00;
   localparam int unsigned OFS_SWGEN  = 'hF00;

   typedef logic [1:0] trig_code_t;
   localparam trig_code_t TRIG_EDGE  = 2'b10;
   localparam trig_code_t TRIG_LEVEL = 2'b01;
endpackage

// File: rtl/irq_setclr_bank.sv
// One bitmap reached through a write-one-to-set and a write-one-to-clear
// window. Strobe inputs from hardware are applied after register writes,
// so they win; a strobe clear beats a strobe set.
module irq_setclr_bank #(
   parameter int unsigned N       = 64,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned SET_OFS = 0,
   parameter int unsigned CLR_OFS = 4,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [N-1:0]      hw_set,
   input  logic [N-1:0]      hw_clr,
   output logic [N-1:0]      q
);
   localparam int unsigned WORDS = N / 32;

   logic [N-1:0] set_v, clr_v, nxt;

   always_comb begin
      set_v = '0;
      clr_v = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (wr && addr == ADDR_W'(SET_OFS + 32'(4 * w))) set_v[32*w +: 32] = wdata;
         if (wr && addr == ADDR_W'(CLR_OFS + 32'(4 * w))) clr_v[32*w +: 32] = wdata;
      end
      nxt = (((q | set_v) & ~clr_v) | hw_set) & ~hw_clr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

   AST_HW_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_clr) |=> ((q & $past(hw_clr)) == '0)); // R11
   AST_HW_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hw_set & ~hw_clr)) |=> ((q & $past(hw_set & ~hw_clr)) == $past(hw_set & ~hw_clr))); // R11
   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|set_v) && !(|clr_v) && !(|hw_set) && !(|hw_clr)) |=> (q == $past(q))); // R4
endmodule

// File: rtl/irq_trigger_unit.sv
// Per peripheral line: trigger-mode storage, input edge detection and level request.
module irq_trigger_unit #(
   parameter int unsigned N_PER    = 48,
   parameter int unsigned N_SW     = 16,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned TRIG_OFS = 'hC00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       mode_bits,   // odd bits of the written word
   input  logic [N_PER-1:0]  irq_in,
   output logic [N_PER-1:0]  edge_mode,
   output logic [N_PER-1:0]  rise,
   output logic [N_PER-1:0]  level_req
);
   logic [N_PER-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edge_mode <= '0;
         prev_q    <= '0;
      end else begin
         prev_q <= irq_in;
         for (int p = 0; p < N_PER; p++) begin
            if (wr && addr == ADDR_W'(TRIG_OFS + 32'(4 * ((N_SW + p) / 16))))
               edge_mode[p] <= mode_bits[(N_SW + p) % 16];
         end
      end
   end

   assign rise      = irq_in & ~prev_q & edge_mode;
   assign level_req = irq_in & ~edge_mode;

   AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((prev_q & $past(rise)) == $past(rise))); // R7
endmodule

// File: rtl/irq_prio_store.sv
// Eight-bit priority per line, four lines per 32-bit word.
module irq_prio_store #(
   parameter int unsigned N      = 64,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned OFS    = 'h400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [N*8-1:0]    prio
);
   localparam int unsigned WORDS = N / 4;

   always_ff @(posedge clk) begin
      if (!rst_n) prio <= '0;
      else begin
         for (int w = 0; w < WORDS; w++) begin
            if (wr && addr == ADDR_W'(OFS + 32'(4 * w))) prio[32*w +: 32] <= wdata;
         end
      end
   end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
   import irq_dist_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned NUM_SW    = 16,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned ID_W     = $clog2(NUM_LINES),
   localparam int unsigned N_PER    = NUM_LINES - NUM_SW
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   input  logic [N_PER-1:0]       irq_in,
   input  logic                   ack_valid,
   input  logic [ID_W-1:0]        ack_id,
   input  logic                   deact_valid,
   input  logic [ID_W-1:0]        deact_id,
   output logic [NUM_LINES-1:0]   fwd_pend,
   output logic [NUM_LINES*8-1:0] fwd_prio
);
   localparam int unsigned WORDS = NUM_LINES / 32;
   localparam int unsigned SW_W  = $clog2(NUM_SW);

   // elaboration-time parameter checks
   if (NUM_LINES % 32 != 0 || NUM_LINES > 1024) begin : g_bad_lines
      $error("NUM_LINES must be a multiple of 32 and at most 1024");
   end
   if (NUM_SW < 2 || NUM_SW > 16 || (NUM_SW & (NUM_SW - 1)) != 0) begin : g_bad_sw
      $error("NUM_SW must be a power of two from 2 to 16");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end

   logic                   ctrl_en;
   logic [NUM_LINES-1:0]   group_q;
   logic [NUM_LINES-1:0]   en_q, pend_q, act_q, pend_eff;
   logic [NUM_LINES-1:0]   ack_vec, deact_vec, sw_vec, pend_set;
   logic [N_PER-1:0]       edge_mode, rise, level_req;
   logic [15:0]            mode_bits;
   logic [2*NUM_LINES-1:0] trig_rd;
   logic                   sw_wr;

   assign ack_vec   = ack_valid   ? (NUM_LINES'(1) << ack_id)   : '0;
   assign deact_vec = deact_valid ? (NUM_LINES'(1) << deact_id) : '0;
   assign sw_wr     = reg_wr && reg_addr == ADDR_W'(OFS_SWGEN);
   assign sw_vec    = sw_wr ? (NUM_LINES'(1) << reg_wdata[SW_W-1:0]) : '0;
   assign pend_set  = sw_vec | {rise, {NUM_SW{1'b0}}};

   for (genvar j = 0; j < 16; j++) begin : g_mode
      assign mode_bits[j] = reg_wdata[2*j+1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         group_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(OFS_CTRL)) ctrl_en <= reg_wdata[0];
         for (int w = 0; w < WORDS; w++) begin
            if (reg_addr == ADDR_W'(OFS_GROUP + 32'(4 * w))) group_q[32*w +: 32] <= reg_wdata;
         end
      end
   end

   irq_setclr_bank #(
      .N(NUM_LINES), .ADDR_W(ADDR_W), .SET_OFS(OFS_EN_SET), .CLR_OFS(OFS_EN_CLR),
      .RST_VAL({{N_PER{1'b0}}, {NUM_SW{1'b1}}})
   ) u_enable (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .hw_set('0), .hw_clr('0), .q(en_q)
   );

   irq_setclr_bank #(
      .N(NUM_LINES), .ADDR_W(ADDR_W), .SET_OFS(OFS_PD_SET), .CLR_OFS(OFS_PD_CLR),
      .RST_VAL('0)
   ) u_pending (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .hw_set(pend_set), .hw_clr(ack_vec), .q(pend_q)
   );

   irq_setclr_bank #(
      .N(NUM_LINES), .ADDR_W(ADDR_W), .SET_OFS(OFS_AC_SET), .CLR_OFS(OFS_AC_CLR),
      .RST_VAL('0)
   ) u_active (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .hw_set(ack_vec), .hw_clr(deact_vec), .q(act_q)
   );

   irq_trigger_unit #(
      .N_PER(N_PER), .N_SW(NUM_SW), .ADDR_W(ADDR_W), .TRIG_OFS(OFS_TRIG)
   ) u_trigger (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .mode_bits(mode_bits),
      .irq_in(irq_in), .edge_mode(edge_mode), .rise(rise), .level_req(level_req)
   );

   irq_prio_store #(
      .N(NUM_LINES), .ADDR_W(ADDR_W), .OFS(OFS_PRIO)
   ) u_prio (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .prio(fwd_prio)
   );

   assign pend_eff = pend_q | ({level_req, {NUM_SW{1'b0}}} & ~act_q);
   assign fwd_pend = {NUM_LINES{ctrl_en}} & en_q & pend_eff;

   // trigger read-back: software lines fixed, peripheral lines from stored mode
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_trig
      if (i < NUM_SW) begin : g_fixed
         assign trig_rd[2*i +: 2] = TRIG_EDGE;
      end else begin : g_cfg
         assign trig_rd[2*i +: 2] = edge_mode[i-NUM_SW] ? TRIG_EDGE : TRIG_LEVEL;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_CTRL)) reg_rdata = {31'd0, ctrl_en};
      if (reg_addr == ADDR_W'(OFS_TYPE)) reg_rdata = 32'(NUM_LINES);
      for (int w = 0; w < WORDS; w++) begin
         if (reg_addr == ADDR_W'(OFS_GROUP + 32'(4*w))) reg_rdata = group_q[32*w +: 32];
         if (reg_addr == ADDR_W'(OFS_EN_SET + 32'(4*w)) ||
             reg_addr == ADDR_W'(OFS_EN_CLR + 32'(4*w))) reg_rdata = en_q[32*w +: 32];
         if (reg_addr == ADDR_W'(OFS_PD_SET + 32'(4*w)) ||
             reg_addr == ADDR_W'(OFS_PD_CLR + 32'(4*w))) reg_rdata = pend_eff[32*w +: 32];
         if (reg_addr == ADDR_W'(OFS_AC_SET + 32'(4*w)) ||
             reg_addr == ADDR_W'(OFS_AC_CLR + 32'(4*w))) reg_rdata = act_q[32*w +: 32];
      end
      for (int w = 0; w < NUM_LINES / 4; w++) begin
         if (reg_addr == ADDR_W'(OFS_PRIO + 32'(4*w))) reg_rdata = fwd_prio[32*w +: 32];
      end
      for (int w = 0; w < NUM_LINES / 16; w++) begin
         if (reg_addr == ADDR_W'(OFS_TRIG + 32'(4*w))) reg_rdata = trig_rd[32*w +: 32];
      end
   end

   AST_ACK_MAKES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !(deact_valid && deact_id == ack_id)) |=> act_q[$past(ack_id)]); // R11
   AST_SWGEN_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !(ack_valid && ack_id == ID_W'(reg_wdata[SW_W-1:0])))
      |=> pend_q[$past(reg_wdata[SW_W-1:0])]); // R9
endmodule

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb;
   localparam int NL = 64;
   localparam int NS = 16;
   localparam int NP = NL - NS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [11:0]   reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] irq_in = '0;
   logic          ack_valid = 1'b0;
   logic [5:0]    ack_id = '0;
   logic          deact_valid = 1'b0;
   logic [5:0]    deact_id = '0;
   logic [NL-1:0] fwd_pend;
   logic [NL*8-1:0] fwd_prio;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   irq_dist_regs u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
      .ack_valid(ack_valid), .ack_id(ack_id), .deact_valid(deact_valid),
      .deact_id(deact_id), .fwd_pend(fwd_pend), .fwd_prio(fwd_prio)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000 && !done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog: run hung, actual=%0d expected<50000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rdchk(string tag, logic [11:0] a, logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, 64'(reg_rdata), 64'(exp));
   endtask

   function automatic logic [7:0] pval(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   initial begin
      logic [63:0] snap;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R3 type word
      rdchk("R1 ctrl", 12'h000, 32'h0);
      rdchk("R3 type", 12'h004, 32'd64);
      rdchk("R1 en set w0", 12'h100, 32'h0000FFFF);
      rdchk("R1 en clr w0", 12'h180, 32'h0000FFFF);
      rdchk("R1 en w1", 12'h104, 32'h0);
      for (int w = 0; w < 2; w++) begin
         rdchk("R1 pend", 12'(12'h200 + 4*w), 32'h0);
         rdchk("R1 act", 12'(12'h300 + 4*w), 32'h0);
         rdchk("R1 group", 12'(12'h080 + 4*w), 32'h0);
      end
      rdchk("R1 trig sw", 12'hC00, 32'hAAAAAAAA);
      for (int w = 1; w < 4; w++) rdchk("R1 trig per", 12'(12'hC00 + 4*w), 32'h55555555);
      for (int w = 0; w < 16; w++) rdchk("R1 prio", 12'(12'h400 + 4*w), 32'h0);
      chk("R1 fwd", fwd_pend, 64'h0);

      // R4 set/clear windows, write-zero is a no-op
      for (int k = 0; k < 3; k++) begin
         logic [11:0] sa, ca;
         sa = 12'(12'h104 + 12'h100 * k);
         ca = 12'(12'h184 + 12'h100 * k);
         wr(sa, 32'h0F0F0000);
         rdchk("R4 set rd", sa, 32'h0F0F0000);
         rdchk("R4 clr rd", ca, 32'h0F0F0000);
         wr(sa, 32'h0);
         rdchk("R4 set zero", sa, 32'h0F0F0000);
         wr(ca, 32'h0F000000);
         rdchk("R4 clr", sa, 32'h000F0000);
         wr(ca, 32'h0);
         rdchk("R4 clr zero", ca, 32'h000F0000);
         wr(ca, 32'hFFFFFFFF);
         rdchk("R4 clr all", sa, 32'h0);
      end

      // R5 priority sweep, R12 forwarded priorities
      for (int w = 0; w < 16; w++)
         wr(12'(12'h400 + 4*w), {pval(4*w+3), pval(4*w+2), pval(4*w+1), pval(4*w)});
      for (int w = 0; w < 16; w++)
         rdchk("R5 prio rd", 12'(12'h400 + 4*w),
               {pval(4*w+3), pval(4*w+2), pval(4*w+1), pval(4*w)});
      for (int i = 0; i < NL; i++) chk("R12 fwd_prio", 64'(fwd_prio[8*i +: 8]), 64'(pval(i)));

      // R6 trigger fields
      wr(12'hC00, 32'hFFFFFFFF);
      rdchk("R6 sw fixed", 12'hC00, 32'hAAAAAAAA);
      wr(12'hC04, 32'h00000000);
      rdchk("R6 level", 12'hC04, 32'h55555555);
      wr(12'hC04, 32'hFFFFFFFF);
      rdchk("R6 edge", 12'hC04, 32'hAAAAAAAA);

      wr(12'h000, 32'h1);
      rdchk("R2 ctrl on", 12'h000, 32'h1);

      // R7 edge line 20 (irq_in[4])
      wr(12'h100, 32'h1 << 20);
      @(negedge clk); irq_in[4] = 1'b1;
      @(negedge clk); irq_in[4] = 1'b0;
      repeat (3) @(negedge clk);
      rdchk("R7 edge latched", 12'h200, 32'h1 << 20);
      chk("R7 fwd", 64'(fwd_pend[20]), 64'd1);
      wr(12'h280, 32'h1 << 20);
      rdchk("R7 cleared", 12'h200, 32'h0);

      // R8 level line 40 (irq_in[24], word 1 bit 8)
      wr(12'h104, 32'h1 << 8);
      @(negedge clk); irq_in[24] = 1'b1;
      rdchk("R8 level high", 12'h204, 32'h100);
      chk("R8 fwd", 64'(fwd_pend[40]), 64'd1);
      // R2 global enable hides but keeps pending
      wr(12'h000, 32'h0);
      chk("R2 hidden", fwd_pend, 64'h0);
      rdchk("R2 still pending", 12'h204, 32'h100);
      wr(12'h000, 32'h1);
      chk("R2 shown", 64'(fwd_pend[40]), 64'd1);
      // R10 group has no effect
      snap = fwd_pend;
      wr(12'h080, 32'hFFFFFFFF);
      wr(12'h084, 32'hFFFFFFFF);
      rdchk("R10 group rd0", 12'h080, 32'hFFFFFFFF);
      rdchk("R10 group rd1", 12'h084, 32'hFFFFFFFF);
      chk("R10 fwd same", fwd_pend, snap);
      // R11 level ack then deactivate
      @(negedge clk); ack_valid = 1'b1; ack_id = 6'd40;
      @(negedge clk); ack_valid = 1'b0;
      rdchk("R11 lvl active", 12'h304, 32'h100);
      rdchk("R8 not pending while active", 12'h204, 32'h0);
      chk("R11 lvl fwd off", 64'(fwd_pend[40]), 64'd0);
      @(negedge clk); deact_valid = 1'b1; deact_id = 6'd40;
      @(negedge clk); deact_valid = 1'b0;
      rdchk("R11 lvl inactive", 12'h304, 32'h0);
      rdchk("R8 pending again", 12'h204, 32'h100);
      @(negedge clk); irq_in[24] = 1'b0;
      rdchk("R8 level low", 12'h204, 32'h0);

      // R9 software interrupt
      wr(12'hF00, 32'h7);
      rdchk("R9 sw 7", 12'h200, 32'h80);
      chk("R9 fwd 7", 64'(fwd_pend[7]), 64'd1);
      wr(12'hF00, 32'h1F);
      rdchk("R9 sw 15 upper ignored", 12'h200, 32'h8080);
      wr(12'h280, 32'h8000);

      // R11 precedence over same-cycle writes
      @(negedge clk);
      ack_valid = 1'b1; ack_id = 6'd7;
      reg_wr = 1'b1; reg_addr = 12'h200; reg_wdata = 32'h80;
      @(negedge clk);
      ack_valid = 1'b0; reg_wr = 1'b0;
      rdchk("R11 ack beats set", 12'h200, 32'h0);
      rdchk("R11 ack active", 12'h300, 32'h80);
      @(negedge clk);
      deact_valid = 1'b1; deact_id = 6'd7;
      reg_wr = 1'b1; reg_addr = 12'h300; reg_wdata = 32'h80;
      @(negedge clk);
      deact_valid = 1'b0; reg_wr = 1'b0;
      rdchk("R11 deact beats set", 12'h300, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule